// File: doc/BRIEF.md
# Program Image Stream Loader

This block accepts a packed program image one bit per accepted handshake and turns it into write commands. The image carries no byte framing. It is a chain of variable-length records, and each record declares its own lengths. The block breaks the image into two kinds of record, constants and code sections, and emits one command per finished constant and one command per code bit.

Constant commands target the shared segment (segment 0). Each one carries the register number, the sign, the declared length and the value, right-justified. Code commands carry a segment number, a bit address and one data bit.

The segment of the first section in the image is the program entry. It is presented together with a completion flag once the image has been consumed. Two faults stop the load until the next reset:
- a constant wider than the supported register width raises a format error;
- an end-of-stream marker that arrives before the image is complete raises a truncation error.

Top module: `img_loader`

## Requirements
- R1: The image is a 32-bit constant count, that many constant records, a 32-bit section count, then that many section records. Every multi-bit field arrives most significant bit first. A constant record is a 32-bit register number, a 1-bit sign (1 = negative), a 32-bit length L, then L value bits. One cycle after its last value bit is accepted, `const_we` pulses for one cycle with the register, sign, L and the value right-justified, all bits above L being zero.
- R2: A constant with L = 0 produces its write one cycle after the last length bit is accepted, with length 0 and value 0. The next record's field starts with the following accepted bit.
- R3: A constant with L greater than REG_W stops the load. `err_format` is set and `s_ready` drops one cycle after the last length bit, and no further write follows. L equal to REG_W is accepted.
- R4: A section record is a 32-bit segment number, a 32-bit code length N, then N code bits. One cycle after each code bit is accepted, `code_we` pulses with that segment, the bit, and an address that starts at 0 and rises by one per code bit.
- R5: `entry_seg` holds the segment number of the first section record. `load_done` rises in the same cycle as the write of the final code bit of the last section, or one cycle after the last length bit when that section is empty.
- R6: A constant count of 0 moves straight to the section count. A section count of 0 ends the load with `load_done` = 1 and `entry_seg` = 0.
- R7: When `s_last` accompanies an accepted bit that does not complete the image, `err_trunc` is set, `s_ready` drops and `load_done` stays 0. When `s_last` comes with the final bit, no error is raised.
- R8: Cycles with `s_valid` low change nothing: no write is issued and `s_bit` and `s_last` are ignored.
- R9: After reset, `s_ready` = 1 and all flags and write strobes are 0. After completion or an error, `s_ready` stays 0 and the flags hold until reset.
- R10: A constant write and a code write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Stream bit valid |
| s_bit | input | 1 | Stream data bit |
| s_last | input | 1 | Marks the final bit the source will send |
| s_ready | output | 1 | Loader accepts a bit this cycle |
| const_we | output | 1 | Constant write strobe |
| const_reg | output | FW | Constant register number |
| const_sign | output | 1 | Constant sign |
| const_len | output | FW | Constant length in bits |
| const_val | output | REG_W | Constant value, right-justified |
| code_we | output | 1 | Code bit write strobe |
| code_seg | output | FW | Target segment of the code bit |
| code_addr | output | ADDR_W | Bit address inside the segment |
| code_bit | output | 1 | Code bit value |
| load_done | output | 1 | Image fully loaded |
| entry_seg | output | FW | Segment of the first section |
| err_format | output | 1 | Constant longer than REG_W |
| err_trunc | output | 1 | Stream ended early |

## Verification
Two pairs of events can land in one cycle. The final code bit of the last section raises `code_we` and `load_done` together. The end marker can also arrive with the bit that completes a record, and then it decides between completion and truncation. The bench sends a directed image whose last section is not empty and checks `load_done` on the very sample that shows the last code write. It also cuts an image exactly at the end of a section while another section is still declared, and expects the write and `err_trunc` together with no completion. Random images with random idle gaps, during which `s_bit` and `s_last` are toggled, are compared write by write against queues the bench builds while encoding the image.

// File: rtl/img_loader_pkg.sv
package img_loader_pkg;
  typedef enum logic [3:0] {
    ST_NCONST,
    ST_CREG,
    ST_CSIGN,
    ST_CLEN,
    ST_CVAL,
    ST_NSEC,
    ST_SSEG,
    ST_SLEN,
    ST_SCODE,
    ST_DONE,
    ST_FAIL
  } ld_state_e;
endpackage

// File: rtl/img_shift_field.sv
// MSB-first shift collector. Holds W-1 past bits; the full W-bit word is
// formed with the live input bit so a field completes on its last bit.
module img_shift_field #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] full
);
  logic [W-2:0] hist_q;

  assign full = {hist_q, bit_in};

  always_ff @(posedge clk) begin
    if (rst || clr) hist_q <= '0;
    else if (shift_en) hist_q <= full[W-2:0];
  end
endmodule

// File: rtl/img_parse_ctrl.sv
module img_parse_ctrl
  import img_loader_pkg::*;
#(
  parameter int FW     = 32,
  parameter int REG_W  = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic              s_bit,
  input  logic              s_last,
  input  logic [FW-1:0]     fld_full,
  input  logic [REG_W-1:0]  val_full,
  output logic              fld_shift,
  output logic              val_shift,
  output logic              val_clr,
  output logic              s_ready,
  output logic              const_we,
  output logic [FW-1:0]     const_reg,
  output logic              const_sign,
  output logic [FW-1:0]     const_len,
  output logic [REG_W-1:0]  const_val,
  output logic              code_we,
  output logic [FW-1:0]     code_seg,
  output logic [ADDR_W-1:0] code_addr,
  output logic              code_bit,
  output logic              load_done,
  output logic [FW-1:0]     entry_seg,
  output logic              err_format,
  output logic              err_trunc
);
  localparam logic [FW-1:0] FLD_LAST = FW'(FW - 1);
  localparam logic [FW-1:0] LEN_MAX  = FW'(REG_W);
  localparam logic [FW-1:0] ONE      = FW'(1);

  ld_state_e   st_q, nxt;
  logic [FW-1:0] bitcnt_q, rem_q, len_q, creg_q, seg_q;
  logic        csign_q, first_q, ready_q;
  logic        acc, f_end, d_end, fld_zero;
  logic        cnt_clr, c_emit, k_emit, fmt, rec_done, trunc, in_const;

  assign acc       = s_valid && ready_q;
  assign f_end     = (bitcnt_q == FLD_LAST);
  assign d_end     = (bitcnt_q == len_q - ONE);
  assign fld_zero  = (fld_full == '0);
  assign fld_shift = acc;
  assign val_shift = acc && (st_q == ST_CVAL);
  assign val_clr   = acc && (st_q == ST_CLEN) && f_end;
  assign s_ready   = ready_q;

  always_comb begin
    nxt      = st_q;
    cnt_clr  = 1'b0;
    c_emit   = 1'b0;
    k_emit   = 1'b0;
    fmt      = 1'b0;
    rec_done = 1'b0;
    in_const = (st_q == ST_CLEN) || (st_q == ST_CVAL);
    case (st_q)
      ST_NCONST: if (f_end) begin
        cnt_clr = 1'b1;
        nxt     = fld_zero ? ST_NSEC : ST_CREG;
      end
      ST_CREG: if (f_end) begin
        cnt_clr = 1'b1;
        nxt     = ST_CSIGN;
      end
      ST_CSIGN: begin
        cnt_clr = 1'b1;
        nxt     = ST_CLEN;
      end
      ST_CLEN: if (f_end) begin
        cnt_clr = 1'b1;
        if (fld_full > LEN_MAX) begin
          fmt = 1'b1;
          nxt = ST_FAIL;
        end else if (fld_zero) begin
          c_emit   = 1'b1;
          rec_done = 1'b1;
        end else begin
          nxt = ST_CVAL;
        end
      end
      ST_CVAL: if (d_end) begin
        cnt_clr  = 1'b1;
        c_emit   = 1'b1;
        rec_done = 1'b1;
      end
      ST_NSEC: if (f_end) begin
        cnt_clr = 1'b1;
        nxt     = fld_zero ? ST_DONE : ST_SSEG;
      end
      ST_SSEG: if (f_end) begin
        cnt_clr = 1'b1;
        nxt     = ST_SLEN;
      end
      ST_SLEN: if (f_end) begin
        cnt_clr = 1'b1;
        if (fld_zero) rec_done = 1'b1;
        else nxt = ST_SCODE;
      end
      ST_SCODE: begin
        k_emit = 1'b1;
        if (d_end) begin
          cnt_clr  = 1'b1;
          rec_done = 1'b1;
        end
      end
      default: ;
    endcase
    if (rec_done) begin
      if (rem_q == ONE) nxt = in_const ? ST_NSEC : ST_DONE;
      else nxt = in_const ? ST_CREG : ST_SSEG;
    end
    trunc = s_last && (nxt != ST_DONE) && (nxt != ST_FAIL);
  end

  always_ff @(posedge clk) begin
    const_we <= 1'b0;
    code_we  <= 1'b0;
    if (rst) begin
      st_q       <= ST_NCONST;
      bitcnt_q   <= '0;
      rem_q      <= '0;
      len_q      <= '0;
      creg_q     <= '0;
      seg_q      <= '0;
      csign_q    <= 1'b0;
      first_q    <= 1'b1;
      ready_q    <= 1'b1;
      load_done  <= 1'b0;
      entry_seg  <= '0;
      err_format <= 1'b0;
      err_trunc  <= 1'b0;
      const_reg  <= '0;
      const_sign <= 1'b0;
      const_len  <= '0;
      const_val  <= '0;
      code_seg   <= '0;
      code_addr  <= '0;
      code_bit   <= 1'b0;
    end else if (acc) begin
      bitcnt_q <= cnt_clr ? '0 : bitcnt_q + ONE;
      st_q     <= trunc ? ST_FAIL : nxt;
      ready_q  <= !(trunc || nxt == ST_DONE || nxt == ST_FAIL);
      if (trunc) err_trunc <= 1'b1;
      if (fmt) err_format <= 1'b1;
      if (nxt == ST_DONE) load_done <= 1'b1;
      case (st_q)
        ST_NCONST, ST_NSEC: if (f_end) rem_q <= fld_full;
        ST_CREG:            if (f_end) creg_q <= fld_full;
        ST_CSIGN:           csign_q <= s_bit;
        ST_CLEN, ST_SLEN:   if (f_end) len_q <= fld_full;
        ST_SSEG: if (f_end) begin
          seg_q <= fld_full;
          if (first_q) begin
            entry_seg <= fld_full;
            first_q   <= 1'b0;
          end
        end
        default: ;
      endcase
      if (rec_done) rem_q <= rem_q - ONE;
      if (c_emit) begin
        const_we   <= 1'b1;
        const_reg  <= creg_q;
        const_sign <= csign_q;
        const_len  <= (st_q == ST_CLEN) ? '0 : len_q;
        const_val  <= (st_q == ST_CLEN) ? '0 : val_full;
      end
      if (k_emit) begin
        code_we   <= 1'b1;
        code_seg  <= seg_q;
        code_addr <= bitcnt_q[ADDR_W-1:0];
        code_bit  <= s_bit;
      end
    end
  end
endmodule

// File: rtl/img_loader.sv
module img_loader #(
  parameter int FW     = 32,
  parameter int REG_W  = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic              s_bit,
  input  logic              s_last,
  output logic              s_ready,
  output logic              const_we,
  output logic [FW-1:0]     const_reg,
  output logic              const_sign,
  output logic [FW-1:0]     const_len,
  output logic [REG_W-1:0]  const_val,
  output logic              code_we,
  output logic [FW-1:0]     code_seg,
  output logic [ADDR_W-1:0] code_addr,
  output logic              code_bit,
  output logic              load_done,
  output logic [FW-1:0]     entry_seg,
  output logic              err_format,
  output logic              err_trunc
);
  logic [FW-1:0]    fld_full;
  logic [REG_W-1:0] val_full;
  logic             fld_shift, val_shift, val_clr;

  img_shift_field #(.W(FW)) u_fld (
    .clk(clk), .rst(rst), .clr(1'b0), .shift_en(fld_shift),
    .bit_in(s_bit), .full(fld_full)
  );

  img_shift_field #(.W(REG_W)) u_val (
    .clk(clk), .rst(rst), .clr(val_clr), .shift_en(val_shift),
    .bit_in(s_bit), .full(val_full)
  );

  img_parse_ctrl #(.FW(FW), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_bit(s_bit), .s_last(s_last),
    .fld_full(fld_full), .val_full(val_full),
    .fld_shift(fld_shift), .val_shift(val_shift), .val_clr(val_clr),
    .s_ready(s_ready),
    .const_we(const_we), .const_reg(const_reg), .const_sign(const_sign),
    .const_len(const_len), .const_val(const_val),
    .code_we(code_we), .code_seg(code_seg), .code_addr(code_addr),
    .code_bit(code_bit), .load_done(load_done), .entry_seg(entry_seg),
    .err_format(err_format), .err_trunc(err_trunc)
  );
endmodule

// File: rtl/img_loader_chk.sv
module img_loader_chk #(
  parameter int FW     = 32,
  parameter int REG_W  = 64,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              s_valid,
  input logic              s_ready,
  input logic              const_we,
  input logic [FW-1:0]     const_len,
  input logic [REG_W-1:0]  const_val,
  input logic              code_we,
  input logic [ADDR_W-1:0] code_addr,
  input logic              load_done,
  input logic              err_format,
  input logic              err_trunc
);
  logic [ADDR_W-1:0] last_addr_q;

  always_ff @(posedge clk) begin
    if (rst) last_addr_q <= '0;
    else if (code_we) last_addr_q <= code_addr;
  end

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    const_we |-> const_len <= FW'(REG_W)); // R3

  AST_VALUE_JUSTIFIED: assert property (@(posedge clk) disable iff (rst)
    (const_we && const_len < FW'(REG_W)) |-> ((const_val >> const_len) == '0)); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (code_we && code_addr != '0) |-> code_addr == last_addr_q + 1'b1); // R4

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready) |=> !(const_we || code_we)); // R8

  AST_END_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (load_done || err_format || err_trunc) |=> (!s_ready && $stable(load_done)
      && $stable(err_format) && $stable(err_trunc))); // R9

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(const_we && code_we)); // R10

  AST_TRUNC_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    err_trunc |-> !load_done); // R7
endmodule

bind img_loader img_loader_chk #(.FW(FW), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .const_we(const_we), .const_len(const_len), .const_val(const_val),
  .code_we(code_we), .code_addr(code_addr), .load_done(load_done),
  .err_format(err_format), .err_trunc(err_trunc)
);

// File: tb/img_loader_bench.sv
module img_loader_bench;
  localparam int FW = 32, RW = 64, AW = 32;

  logic clk = 1'b0;
  logic rst, s_valid, s_bit, s_last;
  logic s_ready, const_we, const_sign, code_we, code_bit, load_done, err_format, err_trunc;
  logic [FW-1:0] const_reg, const_len, code_seg, entry_seg;
  logic [RW-1:0] const_val;
  logic [AW-1:0] code_addr;

  always #10 clk = ~clk;

  img_loader #(.FW(FW), .REG_W(RW), .ADDR_W(AW)) u_img_loader (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_bit(s_bit), .s_last(s_last),
    .s_ready(s_ready), .const_we(const_we), .const_reg(const_reg),
    .const_sign(const_sign), .const_len(const_len), .const_val(const_val),
    .code_we(code_we), .code_seg(code_seg), .code_addr(code_addr),
    .code_bit(code_bit), .load_done(load_done), .entry_seg(entry_seg),
    .err_format(err_format), .err_trunc(err_trunc)
  );

  typedef struct packed { logic [31:0] r; logic s; logic [31:0] l; logic [63:0] v; } cexp_t;
  typedef struct packed { logic [31:0] g; logic [31:0] a; logic b; } kexp_t;

  int checks = 0, errors = 0;
  logic  bits_q[$];
  cexp_t ce[$];
  kexp_t ke[$];
  bit    last_is_done;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bits_q.push_back(v[i]);
  endtask

  function automatic logic [63:0] lmask(input int l);
    return (l >= 64) ? '1 : ((64'd1 << l) - 64'd1);
  endfunction

  task automatic add_const(input logic [31:0] r, input logic s, input int l, input logic [63:0] v);
    cexp_t e;
    push(r, 32); push(s, 1); push(l, 32); push(v, l);
    e.r = r; e.s = s; e.l = l; e.v = v & lmask(l);
    ce.push_back(e);
  endtask

  task automatic add_sec(input logic [31:0] g, input int l, input logic [63:0] code);
    kexp_t e;
    push(g, 32); push(l, 32); push(code, l);
    for (int a = 0; a < l; a++) begin
      e.g = g; e.a = a; e.b = code[l - 1 - a];
      ke.push_back(e);
    end
  endtask

  task automatic sample();
    cexp_t c;
    kexp_t k;
    if (const_we && code_we) chk(0, "R10 both writes", 1, 0);
    if (const_we) begin
      if (ce.size() == 0) chk(0, "R1 unexpected constant write", const_reg, 0);
      else begin
        c = ce.pop_front();
        chk(const_reg == c.r && const_sign == c.s && const_len == c.l && const_val == c.v,
            "R1 constant write", const_val ^ {const_reg, const_len}, c.v ^ {c.r, c.l});
      end
    end
    if (code_we) begin
      if (ke.size() == 0) chk(0, "R4 unexpected code write", code_addr, 0);
      else begin
        if (last_is_done) chk(load_done == (ke.size() == 1), "R5 done with final code bit", load_done, ke.size() == 1);
        k = ke.pop_front();
        chk(code_seg == k.g && code_addr == k.a && code_bit == k.b,
            "R4 code write", {code_seg, code_addr}, {k.g, k.a});
      end
    end
  endtask

  task automatic do_reset();
    s_valid = 0; s_bit = 0; s_last = 0; rst = 1;
    bits_q.delete(); ce.delete(); ke.delete(); last_is_done = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk(s_ready && !load_done && !err_format && !err_trunc && !const_we && !code_we,
        "R9 reset state", {s_ready, load_done, err_format, err_trunc}, 4'b1000);
  endtask

  task automatic run(input int gap_pct, input bit mark_last);
    int idx = 0;
    forever begin
      @(negedge clk);
      sample();
      if (idx >= bits_q.size() || !s_ready) break;
      if ($urandom_range(99) < gap_pct) begin
        s_valid = 0; s_bit = 1'($urandom); s_last = 1'($urandom);
      end else begin
        s_valid = 1; s_bit = bits_q[idx];
        s_last = mark_last && (idx == bits_q.size() - 1);
        idx++;
      end
    end
    s_valid = 0; s_last = 0;
    repeat (3) begin @(negedge clk); sample(); end
  endtask

  task automatic finish_test(input bit d, input logic [31:0] ent, input bit f, input bit t, input bit empty);
    chk(load_done == d, "R5 done flag", load_done, d);
    if (d) chk(entry_seg == ent, "R5 entry segment", entry_seg, ent);
    chk(err_format == f, "R3 format flag", err_format, f);
    chk(err_trunc == t, "R7 truncation flag", err_trunc, t);
    chk(!s_ready, "R9 ready low after end", s_ready, 0);
    if (empty) chk(ce.size() == 0 && ke.size() == 0, "R4 all writes seen", ce.size() + ke.size(), 0);
  endtask

  initial begin
    #4ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));

    // Directed: zero-length constant, full-width constant, empty then non-empty section
    do_reset();
    repeat (5) begin
      @(negedge clk); s_bit = 1'($urandom); s_last = 1;
      chk(!const_we && !code_we && s_ready, "R8 idle no effect", {const_we, code_we}, 0);
    end
    s_last = 0;
    push(2, 32);
    add_const(32'd3, 1'b1, 0, 64'h0);                    // R2
    add_const(32'd4, 1'b0, 64, 64'hF0E1_D2C3_B4A5_9687); // R3 boundary
    push(2, 32);
    add_sec(32'd1003, 0, 0);
    add_sec(32'd7, 5, 64'h16);
    last_is_done = 1;
    run(20, 1);
    finish_test(1, 32'd1003, 0, 0, 1);

    // R6: no constants, no sections
    do_reset();
    push(0, 32); push(0, 32);
    run(0, 1);
    finish_test(1, 32'd0, 0, 0, 1);

    // R6: no constants, one section
    do_reset();
    push(0, 32); push(1, 32);
    add_sec(32'd1500, 3, 64'h5);
    last_is_done = 1;
    run(30, 0);
    finish_test(1, 32'd1500, 0, 0, 1);

    // Random images
    for (int t = 0; t < 6; t++) begin
      int nc, ns, l;
      logic [31:0] first;
      do_reset();
      nc = $urandom_range(0, 4);
      push(nc, 32);
      for (int i = 0; i < nc; i++) begin
        l = $urandom_range(0, 64);
        add_const($urandom, 1'($urandom), l, {$urandom, $urandom} & lmask(l));
      end
      ns = $urandom_range(1, 3);
      push(ns, 32);
      for (int i = 0; i < ns; i++) begin
        logic [31:0] g = $urandom;
        if (i == 0) first = g;
        l = (i == ns - 1) ? $urandom_range(1, 64) : $urandom_range(0, 64);
        add_sec(g, l, {$urandom, $urandom});
      end
      last_is_done = 1;
      run(25, t % 2);
      finish_test(1, first, 0, 0, 1);
    end

    // R3: constant longer than the register width
    do_reset();
    push(2, 32);
    add_const(32'd9, 1'b0, 10, 64'h2A5);
    push(32'd10, 32); push(0, 1); push(65, 32); push('1, 64); push(1, 1);
    push(1, 32); add_sec(32'd5, 4, 64'hF); ke.delete();
    run(15, 0);
    finish_test(0, 0, 1, 0, 1);

    // R7: end marker on the last bit of a section while another is declared
    do_reset();
    push(0, 32); push(2, 32);
    add_sec(32'd12, 4, 64'h9);
    run(10, 1);
    finish_test(0, 0, 0, 1, 1);

    // R7: random image cut mid-way
    do_reset();
    push(1, 32);
    add_const(32'd1, 1'b1, 40, {$urandom, $urandom} & lmask(40));
    push(1, 32);
    add_sec(32'd77, 50, {$urandom, $urandom});
    while (bits_q.size() > 120) void'(bits_q.pop_back());
    run(20, 1);
    finish_test(0, 0, 0, 1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule